// File: doc/BRIEF.md
# Three-Key Sequence Lock Controller

This block is a Moore state machine that decides whether a three-key entry on a keypad matches the stored code. By default the code is B, then A, then B. Each clock cycle it takes one 2-bit key code. The code is already synchronous to the clock and may be "no key". When a full attempt matches, the block raises a single-cycle unlock pulse. Throughout the attempt it also reports how many keys have been taken, as a 4-bit value for a display decoder.

Every attempt is exactly three keys long. A mismatching key does not end the attempt early. The machine moves onto a parallel failure track that keeps counting through the third key and then waits. The display therefore looks the same whether the attempt was right or wrong, and it never shows which key was at fault. After the third key, the next key of any kind starts a fresh attempt.

Top module: `keyseq_lock`

## Requirements
- R1: While rst_n is low, the machine is in its idle state: key_count reads 0 and unlock reads 0, and both stay so in the first cycle after release.
- R2: Key codes are 2 bits wide: 2'b00 means no key, 2'b01 is key A, 2'b10 is key B, and 2'b11 is a key that never matches the code.
- R3: In a cycle with key code 2'b00, key_count stays unchanged at the next clock edge.
- R4: A key (any non-zero code) taken while key_count is 0, 1 or 2 raises key_count by exactly one at that clock edge.
- R5: A key taken while key_count is 3 returns key_count to 0 at that clock edge, and unlock is 0 afterwards.
- R6: If the three keys of an attempt are B, A, B in that order, unlock is 1 in the cycle right after the clock edge that takes the third key.
- R7: unlock is 1 for exactly one cycle per correct attempt, even when no key follows. key_count stays at 3 until the next key.
- R8: If any key of an attempt differs from the code at its position (including code 2'b11), key_count still steps through 1, 2 and 3, and unlock stays 0 for that whole attempt.
- R9: key_count never exceeds 3, and unlock is 1 only while key_count is 3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset; must be released synchronously to clk |
| key_code | input | 2 | Key taken this cycle: 00 none, 01 A, 10 B, 11 invalid |
| unlock | output | 1 | One-cycle pulse after a correct three-key attempt |
| key_count | output | 4 | Number of keys taken in the current attempt (0 to 3) |

## Verification
The case that is hardest to reach from the ports is an unlock followed by idle cycles. The pulse has to fall while the count stays at 3, and random keys seldom complete a correct attempt and then go quiet. The stimulus drives that case directly. It also drives a wrong key at each of the three positions, and a reset in the middle of an attempt. Long random runs then use a key distribution weighted toward B and A, so correct attempts occur among wrong and empty cycles.

// File: rtl/lock_pkg.sv
package lock_pkg;

  localparam int KEY_W = 2;
  localparam int ST_W  = 3;

  localparam logic [KEY_W-1:0] KEY_NONE = 2'b00;
  localparam logic [KEY_W-1:0] KEY_A    = 2'b01;
  localparam logic [KEY_W-1:0] KEY_B    = 2'b10;

  // Bit 2 set with nonzero low bits marks the failure track; low bits give the count.
  typedef enum logic [ST_W-1:0] {
    ST_IDLE   = 3'b000,
    ST_OK1    = 3'b001,
    ST_OK2    = 3'b010,
    ST_OK3    = 3'b011,
    ST_OPENED = 3'b100,
    ST_BAD1   = 3'b101,
    ST_BAD2   = 3'b110,
    ST_BAD3   = 3'b111
  } lock_state_e;

endpackage

// File: rtl/lock_next_state.sv
module lock_next_state
  import lock_pkg::*;
#(
  parameter logic [KEY_W-1:0] CODE0 = KEY_B,
  parameter logic [KEY_W-1:0] CODE1 = KEY_A,
  parameter logic [KEY_W-1:0] CODE2 = KEY_B
) (
  input  lock_state_e            cur_state,
  input  logic [KEY_W-1:0]       key_in,
  output lock_state_e            nxt_state,
  output logic                   step_en
);

  logic key_seen;

  assign key_seen = (key_in != KEY_NONE);

  // State moves on a key, or always out of the single-cycle unlock state.
  assign step_en = key_seen || (cur_state == ST_OK3);

  always_comb begin
    nxt_state = cur_state;
    unique case (cur_state)
      ST_IDLE:   if (key_seen) nxt_state = (key_in == CODE0) ? ST_OK1 : ST_BAD1;
      ST_OK1:    if (key_seen) nxt_state = (key_in == CODE1) ? ST_OK2 : ST_BAD2;
      ST_OK2:    if (key_seen) nxt_state = (key_in == CODE2) ? ST_OK3 : ST_BAD3;
      ST_OK3:    nxt_state = key_seen ? ST_IDLE : ST_OPENED;
      ST_OPENED: if (key_seen) nxt_state = ST_IDLE;
      ST_BAD1:   if (key_seen) nxt_state = ST_BAD2;
      ST_BAD2:   if (key_seen) nxt_state = ST_BAD3;
      ST_BAD3:   if (key_seen) nxt_state = ST_IDLE;
      default:   nxt_state = ST_IDLE;
    endcase
  end

endmodule

// File: rtl/lock_state_reg.sv
module lock_state_reg
  import lock_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        load_en,
  input  lock_state_e d_state,
  output lock_state_e q_state
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_state <= ST_IDLE;
    end else if (load_en) begin
      q_state <= d_state;
    end
  end

endmodule

// File: rtl/lock_out_dec.sv
module lock_out_dec
  import lock_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  lock_state_e      cur_state,
  output logic             unlock_o,
  output logic [CNT_W-1:0] count_o
);

  always_comb begin
    unlock_o = 1'b0;
    count_o  = '0;
    unique case (cur_state)
      ST_IDLE:              count_o = CNT_W'(0);
      ST_OK1, ST_BAD1:      count_o = CNT_W'(1);
      ST_OK2, ST_BAD2:      count_o = CNT_W'(2);
      ST_OK3: begin
        count_o  = CNT_W'(3);
        unlock_o = 1'b1;
      end
      ST_OPENED, ST_BAD3:   count_o = CNT_W'(3);
      default:              count_o = '0;
    endcase
  end

endmodule

// File: rtl/keyseq_lock.sv
module keyseq_lock
  import lock_pkg::*;
#(
  parameter int               CNT_W = 4,
  parameter logic [KEY_W-1:0] CODE0 = KEY_B,
  parameter logic [KEY_W-1:0] CODE1 = KEY_A,
  parameter logic [KEY_W-1:0] CODE2 = KEY_B
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [KEY_W-1:0] key_code,
  output logic             unlock,
  output logic [CNT_W-1:0] key_count
);

  lock_state_e state_q;
  lock_state_e state_d;
  logic        state_en;

  lock_next_state #(
    .CODE0(CODE0),
    .CODE1(CODE1),
    .CODE2(CODE2)
  ) nxt_i (
    .cur_state(state_q),
    .key_in   (key_code),
    .nxt_state(state_d),
    .step_en  (state_en)
  );

  lock_state_reg reg_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_en(state_en),
    .d_state(state_d),
    .q_state(state_q)
  );

  lock_out_dec #(
    .CNT_W(CNT_W)
  ) dec_i (
    .cur_state(state_q),
    .unlock_o (unlock),
    .count_o  (key_count)
  );

endmodule

// File: rtl/keyseq_lock_chk.sv
module keyseq_lock_chk #(
  parameter int CNT_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       key_code,
  input logic             unlock,
  input logic [CNT_W-1:0] key_count
);

  // R3
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (key_code == 2'b00) |=> $stable(key_count));

  // R4
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (key_code != 2'b00 && key_count < 3) |=> (key_count == $past(key_count) + 1'b1));

  // R5
  wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (key_code != 2'b00 && key_count == 3) |=> (key_count == 0 && !unlock));

  // R6
  last_key_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(unlock) |-> ($past(key_code) == 2'b10));

  // R7
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    unlock |=> !unlock);

  // R9
  count_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    key_count <= 3);

  // R9
  unlock_at_three_chk: assert property (@(posedge clk) disable iff (!rst_n)
    unlock |-> (key_count == 3));

endmodule

bind keyseq_lock keyseq_lock_chk #(.CNT_W(CNT_W)) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .key_code (key_code),
  .unlock   (unlock),
  .key_count(key_count)
);

// File: tb/keyseq_lock_tb_top.sv
module keyseq_lock_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] key_code = 2'b00;
  logic       unlock;
  logic [3:0] key_count;

  int tests = 0;
  int fails = 0;
  int m_cnt = 0;
  bit m_good = 1'b1;
  bit exp_unlock = 1'b0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  keyseq_lock dut_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .key_code (key_code),
    .unlock   (unlock),
    .key_count(key_count)
  );

  function automatic logic [1:0] code_at(int pos);
    return (pos == 1) ? 2'b01 : 2'b10;
  endfunction

  task automatic check(string req);
    tests++;
    if (key_count !== 4'(m_cnt) || unlock !== exp_unlock) begin
      fails++;
      $display("FAIL %s: count=%0d unlock=%0b expected count=%0d unlock=%0b",
               req, key_count, unlock, m_cnt, exp_unlock);
    end
  endtask

  task automatic step(input logic [1:0] k, input string req);
    @(negedge clk);
    key_code = k;
    @(posedge clk);
    exp_unlock = 1'b0;
    if (k != 2'b00) begin
      if (m_cnt == 3) begin
        m_cnt  = 0;
        m_good = 1'b1;
      end else begin
        m_good = m_good && (k == code_at(m_cnt));
        m_cnt++;
        exp_unlock = (m_cnt == 3) && m_good;
      end
    end
    #2;
    check(req);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    key_code = 2'b00;
    m_cnt = 0; m_good = 1'b1; exp_unlock = 1'b0;
    #3;
    check("R1 during reset");
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    #2;
    check("R1 after release");
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R6 correct attempt back to back
    step(2'b10, "R4 first key");
    step(2'b01, "R4 second key");
    step(2'b10, "R6 third key unlocks");
    // R7 pulse ends although no key follows
    step(2'b00, "R7 pulse one cycle");
    step(2'b00, "R3 hold at three");
    step(2'b01, "R5 wrap to idle");
    // R6 with gaps between keys
    step(2'b10, "R6 gapped");
    step(2'b00, "R3 hold at one");
    step(2'b01, "R6 gapped");
    step(2'b00, "R3 hold at two");
    step(2'b10, "R6 gapped unlock");
    step(2'b10, "R5 wrap right after unlock");
    // R8 wrong key at each position
    for (int p = 0; p < 3; p++) begin
      for (int i = 0; i < 3; i++)
        step((i == p) ? ((p == 1) ? 2'b10 : 2'b01) : code_at(i), "R8 wrong key position");
      step(2'b00, "R8 no unlock");
      step(2'b10, "R5 wrap after failure");
      step(2'b00, "R3 idle gap");
      step(2'b01, "R8 restart wrong");
      step(2'b10, "R8 step");
      step(2'b10, "R8 step to three");
      step(2'b00, "R8 hold");
      step(2'b01, "R5 wrap");
      m_cnt = m_cnt; // attempt restarted above
      step(2'b00, "R3 idle");
      // consume partial attempt to return to idle
      while (m_cnt != 0) step(2'b01, "R5 drain");
    end
    // R2 code 11 never matches
    step(2'b11, "R2 invalid code first");
    step(2'b01, "R2 step");
    step(2'b10, "R2 no unlock");
    step(2'b11, "R2 invalid wraps");
    step(2'b10, "R2 code B");
    step(2'b11, "R2 invalid second");
    step(2'b10, "R2 no unlock");
    // R1 reset in the middle of an attempt
    step(2'b01, "R5 wrap");
    step(2'b10, "R4 key");
    step(2'b01, "R4 key");
    do_reset();
    step(2'b10, "R1 fresh attempt");
    step(2'b01, "R1 fresh attempt");
    step(2'b10, "R6 unlock after reset");
    // random run, weighted toward valid keys
    void'($urandom(32'd1234));
    for (int n = 0; n < 4000; n++) begin
      int r;
      r = $urandom_range(0, 9);
      step((r < 2) ? 2'b00 : (r < 5) ? 2'b01 : (r < 9) ? 2'b10 : 2'b11, "R9 random mix");
    end
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule